// File: doc/BRIEF.md
# Memory Operand Address Former

This block turns the addressing fields of an instruction's operand byte into something a later pipeline stage can use directly. It takes the two-bit mode field, the three-bit operand selector and the width bit, along with the displacement bytes and the current contents of the four general registers that may take part in addressing. In register mode it returns a register index. In every other mode it returns a 16-bit effective address.

The address is a sum of up to three terms: a base register (BX or BP), an index register (SI or DI) and a displacement. Which terms are present depends on the selector. One mode/selector pair is a special case: it drops the base register and uses the displacement alone as an absolute address. A flag reports when BP was one of the summed terms, so that a later stage can pick the stack segment. The result is registered and appears one cycle after a request is presented. Segment arithmetic and the memory access itself are outside this block.

Top module: `ea_gen`

## Requirements
- R1: Outside mode 3, selector values 0, 1, 2 and 3 give BX+SI, BX+DI, BP+SI and BP+DI respectively, plus the displacement term of the mode.
- R2: Outside mode 3, selector values 4, 5 and 7 give SI, DI and BX alone, plus the displacement term. Selector 6 gives BP alone in modes 1 and 2.
- R3: Mode 0 with selector 6 gives the full 16-bit `disp` as the address, with no register added and `bp_based` low.
- R4: In mode 1 the displacement term is `disp[7:0]`, sign-extended to 16 bits. The upper byte of `disp` is ignored.
- R5: In mode 2 the displacement term is the full 16-bit `disp`. In mode 0 (other than selector 6) there is no displacement term.
- R6: The address sum wraps modulo 2^16.
- R7: In mode 3 the outputs are `is_reg`=1 and `reg_code`={`wide`,`rm`}, with `addr`=0 and `bp_based`=0. Codes 0–7 mean AL, CL, DL, BL, AH, CH, DH, BH. Codes 8–15 mean AX, CX, DX, BX, SP, BP, SI, DI. In memory modes `is_reg`=0 and `reg_code`=0.
- R8: `bp_based` is 1 exactly when BP is a summed term: selectors 2 and 3 in modes 0–2, and selector 6 in modes 1 and 2.
- R9: A request accepted at a clock edge with `in_valid`=1 drives `out_valid`=1 and its results after that edge. A cycle with `in_valid`=0 drops `out_valid` and leaves `is_reg`, `reg_code`, `addr` and `bp_based` unchanged.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Addressing mode field |
| rm | input | 3 | Operand selector field |
| wide | input | 1 | Word (1) or byte (0) operand |
| disp | input | AW | Displacement bytes, low byte first in significance |
| bx | input | AW | Current BX contents |
| bp | input | AW | Current BP contents |
| si | input | AW | Current SI contents |
| di | input | AW | Current DI contents |
| out_valid | output | 1 | Result registered from the last cycle's request |
| is_reg | output | 1 | Result is a register index |
| reg_code | output | 4 | Register index {wide, rm} |
| addr | output | AW | Effective address |
| bp_based | output | 1 | BP was part of the sum |

## Verification
The bench builds the block with the default width of AW=16, which is the only width at which the wrap and sign-extension rules have their intended meaning. At that width, all 64 combinations of mode, selector and width bit are small enough to sweep completely. The bench runs that sweep against several register sets and displacements. These include values chosen so that the three-term sum overflows, and a low displacement byte with its top bit set, so the negative 8-bit case is exercised. After each request, an idle cycle with changed inputs confirms that the results are held.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    mode,
  input  logic [2:0]    rm,
  input  logic          wide,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  output logic          out_valid,
  output logic          is_reg,
  output logic [3:0]    reg_code,
  output logic [AW-1:0] addr,
  output logic          bp_based
);

  localparam logic [1:0] MODE_REG = 2'b11;
  localparam logic [2:0] RM_BPONLY = 3'b110;

  logic [AW-1:0] base_t, idx_t, off_t, sum;
  logic          direct, reg_mode, use_bp;

  assign reg_mode = (mode == MODE_REG);
  assign direct   = (mode == 2'b00) && (rm == RM_BPONLY);

  always_comb begin
    base_t = '0;
    idx_t  = '0;
    unique case (rm)
      3'd0: begin base_t = bx; idx_t = si; end
      3'd1: begin base_t = bx; idx_t = di; end
      3'd2: begin base_t = bp; idx_t = si; end
      3'd3: begin base_t = bp; idx_t = di; end
      3'd4: idx_t  = si;
      3'd5: idx_t  = di;
      3'd6: base_t = direct ? '0 : bp;
      3'd7: base_t = bx;
    endcase
  end

  always_comb begin
    unique case (mode)
      2'b00:   off_t = direct ? disp : '0;
      2'b01:   off_t = {{(AW-8){disp[7]}}, disp[7:0]};
      2'b10:   off_t = disp;
      default: off_t = '0;
    endcase
  end

  assign sum    = base_t + idx_t + off_t;
  assign use_bp = !reg_mode && !direct && (rm == 3'd2 || rm == 3'd3 || rm == RM_BPONLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      is_reg    <= 1'b0;
      reg_code  <= '0;
      addr      <= '0;
      bp_based  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_reg   <= reg_mode;
        reg_code <= reg_mode ? {wide, rm} : 4'd0;
        addr     <= reg_mode ? '0 : sum;
        bp_based <= use_bp;
      end
    end
  end

endmodule

module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic [2:0]    rm,
  input logic          wide,
  input logic [AW-1:0] disp,
  input logic [AW-1:0] bx,
  input logic          out_valid,
  input logic          is_reg,
  input logic [3:0]    reg_code,
  input logic [AW-1:0] addr,
  input logic          bp_based
);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr) && $stable(reg_code) && $stable(is_reg) && $stable(bp_based)));

  p_regsel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=>
      (is_reg && reg_code == {$past(wide), $past(rm)} && addr == '0 && !bp_based));

  p_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && rm == 3'd6) |=> (addr == $past(disp) && !bp_based && !is_reg));

  p_bx_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && rm == 3'd7) |=> (addr == $past(bx) && !bp_based));

  p_bp_mem_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bp_based |-> !is_reg);

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .rm(rm),
  .wide(wide), .disp(disp), .bx(bx), .out_valid(out_valid), .is_reg(is_reg),
  .reg_code(reg_code), .addr(addr), .bp_based(bp_based)
);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  rm = '0;
  logic        wide = 1'b0;
  logic [15:0] disp = '0, bx = '0, bp = '0, si = '0, di = '0;
  logic        out_valid, is_reg, bp_based;
  logic [3:0]  reg_code;
  logic [15:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ea_gen #(.AW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .rm(rm),
    .wide(wide), .disp(disp), .bx(bx), .bp(bp), .si(si), .di(di),
    .out_valid(out_valid), .is_reg(is_reg), .reg_code(reg_code),
    .addr(addr), .bp_based(bp_based)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (mode=%0d rm=%0d w=%0d)",
               req, act, exp, mode, rm, wide);
    end
  endtask

  function automatic int exp_addr(input int m, input int r, input int d,
                                  input int vbx, input int vbp, input int vsi, input int vdi);
    int b, x, o;
    b = (r == 0 || r == 1 || r == 7) ? vbx :
        (r == 2 || r == 3 || (r == 6 && m != 0)) ? vbp : 0;
    x = (r == 0 || r == 2 || r == 4) ? vsi :
        (r == 1 || r == 3 || r == 5) ? vdi : 0;
    if (m == 1)                 o = ((d & 'h80) != 0) ? (d & 'hff) - 256 : (d & 'hff);
    else if (m == 2)            o = d;
    else if (m == 0 && r == 6)  o = d;
    else                        o = 0;
    return (b + x + o) & 'hffff;
  endfunction

  function automatic string tag_of(input int m, input int r);
    if (m == 0 && r == 6) return "R3";
    if (m == 1)           return "R4/R6";
    if (m == 2)           return "R5/R6";
    if (r < 4)            return "R1";
    return "R2";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] regset [3][4];
    logic [15:0] dset [3];
    logic [15:0] held;
    int e, eb;
    regset[0] = '{16'h1234, 16'h4000, 16'h0010, 16'h0200};
    regset[1] = '{16'hffff, 16'h8001, 16'hfffe, 16'h7fff};
    regset[2] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    dset = '{16'h0005, 16'h12f0, 16'h80a5};

    in_valid = 1'b1; mode = 2'b10; bx = 16'h1111; disp = 16'h2222;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 addr", int'(addr), 0);
    chk("R10 reg_code", int'(reg_code), 0);
    chk("R10 is_reg/bp_based", int'({is_reg, bp_based}), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", int'(out_valid), 0);

    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 3; k++) begin
        for (int m = 0; m < 4; m++) begin
          for (int r = 0; r < 8; r++) begin
            for (int w = 0; w < 2; w++) begin
              bx = regset[s][0]; bp = regset[s][1]; si = regset[s][2]; di = regset[s][3];
              disp = dset[k];
              mode = 2'(m); rm = 3'(r); wide = 1'(w);
              in_valid = 1'b1;
              @(negedge clk);
              chk("R9 out_valid", int'(out_valid), 1);
              if (m == 3) begin
                chk("R7 is_reg", int'(is_reg), 1);
                chk("R7 reg_code", int'(reg_code), w * 8 + r);
                chk("R7 addr", int'(addr), 0);
                chk("R7 bp_based", int'(bp_based), 0);
              end else begin
                e  = exp_addr(m, r, int'(dset[k]), int'(regset[s][0]), int'(regset[s][1]),
                              int'(regset[s][2]), int'(regset[s][3]));
                eb = (r == 2 || r == 3 || (r == 6 && m != 0)) ? 1 : 0;
                chk(tag_of(m, r), int'(addr), e);
                chk("R8 bp_based", int'(bp_based), eb);
                chk("R7 memory is_reg/reg_code", int'({is_reg, reg_code}), 0);
              end
              held = addr;
              in_valid = 1'b0;
              mode = ~mode; rm = ~rm; disp = ~disp; bx = ~bx; bp = ~bp;
              @(negedge clk);
              chk("R9 idle drop", int'(out_valid), 0);
              chk("R9 idle hold addr", int'(addr), int'(held));
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule